// File: doc/BRIEF.md
# Multi-Output Interrupt Aggregator with Per-Source Trigger Configuration

This block gathers sixty-four interrupt request lines and presents them to three independent control groups, each of which raises one active-high level request toward a primary interrupt controller. A single shared trigger unit decides how every source is sensed. The choice is one of rising edge, falling edge, high level or low level. That sensed value is then fanned out to all three groups, and each group applies its own enable mask and its own software-forced bits.

Software reaches every register over a plain 32-bit word bus with separate read and write strobes. Sources are split into a low bank (lines 0..31) and a high bank (lines 32..63). An interrupt handler reads the status words of its group and scans them. It clears a latched edge event by writing ones to the trigger unit's latch register. Input lines may be asynchronous, so they pass through a synchronizer before any sensing.

Top module: `intr_fanin_hub`

## Requirements
- R1: Address bits [9:8] select a page. Page 0 is group 0, page 1 is group 1, page 3 is group 2 and page 2 is the trigger unit. Within a group page the high-bank registers start at byte 0x18; within the trigger page they start at byte 0x20.
- R2: Group register index 2 (byte +0x08) sets enable bits and index 3 (+0x0C) clears them. Only bits written as 1 change, and both indices read back the enable mask of the bank.
- R3: Group index 4 (+0x10) sets software-pending bits and index 5 (+0x14) clears them. Only bits written as 1 change, and both indices read back the pending mask.
- R4: Trigger index 2 (+0x08) loads the rise configuration and index 3 (+0x0C) loads the fall configuration, each as a whole word. Indices 4/5 set/clear rise bits and indices 6/7 set/clear fall bits, acting only on 1 bits. Reads of 2, 4 and 5 return the rise word; reads of 3, 6 and 7 return the fall word.
- R5: A source with rise=0, fall=0 is sensed as its input (level high). A source with both bits set is sensed as the inverse of its input (level low). Trigger index 0 reads the sensed vector, which follows an input change within four clock cycles through a two-stage synchronizer.
- R6: A source with only rise set latches an event on a 0-to-1 input change. A source with only fall set latches on 1-to-0. Its sensed value is the latched event, which trigger index 1 reads back.
- R7: Writing ones to trigger index 1 clears those latched events, and bits written 0 are untouched. An event detected in the same cycle as its acknowledge stays latched.
- R8: Group index 1 (raw) reads the sensed vector ORed with that group's software-pending bits. Index 0 (status) reads raw ANDed with that group's enable mask.
- R9: irq_out[g] is high exactly when any status bit of group g is set, and depends on no other group's enables or pending bits.
- R10: After reset all enables, configuration, latched events and pending bits are zero. Read data appears on bus_rdata after the clock edge that samples bus_rd. Unmapped words return zero: group words at or above 0x30, trigger words at or above 0x40, or any address with bits [1:0] not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | 64 | Interrupt source lines |
| irq_out | output | 3 | Level requests, one per group |

## Verification
The trigger unit can detect a new edge event in the same clock edge at which software acknowledges that bit. The bench provokes this by timing the input change so that the synchronized edge arrives exactly as the write-one-to-clear lands. It then judges by reading the latch word, which must still hold the bit, and a second acknowledge must clear it. A sweep over every pair of consecutive input nibbles, applied to all four trigger modes in both banks, checks the sensed, latched, raw and status words and the request outputs against arithmetic expectations.

// File: rtl/ihub_pkg.sv
package ihub_pkg;

   localparam int CTL_REGS  = 6;
   localparam int EDGE_REGS = 8;

   localparam logic [1:0] EDGE_PAGE = 2'd2;

   localparam logic [2:0] C_STAT  = 3'd0;
   localparam logic [2:0] C_RAW   = 3'd1;
   localparam logic [2:0] C_ENSET = 3'd2;
   localparam logic [2:0] C_ENCLR = 3'd3;
   localparam logic [2:0] C_SWSET = 3'd4;
   localparam logic [2:0] C_SWCLR = 3'd5;

   localparam logic [2:0] E_SENSE = 3'd0;
   localparam logic [2:0] E_LATCH = 3'd1;
   localparam logic [2:0] E_RISE  = 3'd2;
   localparam logic [2:0] E_FALL  = 3'd3;
   localparam logic [2:0] E_RSET  = 3'd4;
   localparam logic [2:0] E_RCLR  = 3'd5;
   localparam logic [2:0] E_FSET  = 3'd6;
   localparam logic [2:0] E_FCLR  = 3'd7;

   // page code of each output group; the trigger unit sits in the gap at 2
   function automatic logic [1:0] grp_page(input int g);
      case (g)
         0:       return 2'd0;
         1:       return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/ihub_sync.sv
module ihub_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ihub_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ihub_trigger.sv
module ihub_trigger
   import ihub_pkg::*;
#(
   parameter int BANK_W = 32,
   parameter int BANKS  = 2,
   parameter int BIDX_W = 1,
   localparam int N     = BANK_W * BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BIDX_W-1:0] bank,
   input  logic [2:0]        idx,
   input  logic [BANK_W-1:0] wdata,
   input  logic [N-1:0]      sync_in,
   output logic [N-1:0]      sensed,
   output logic [N-1:0]      rise_q,
   output logic [N-1:0]      fall_q,
   output logic [N-1:0]      latch_q,
   output logic [BANK_W-1:0] rd_word
);

   logic [N-1:0] prev_q;
   logic [N-1:0] rise_d, fall_d, ack, evt;
   logic [N-1:0] edge_mode, low_mode;

   assign edge_mode = rise_q ^ fall_q;
   assign low_mode  = rise_q & fall_q;

   // event detection on the synchronized line against its last value
   assign evt = (rise_q & ~fall_q &  sync_in & ~prev_q)
              | (fall_q & ~rise_q & ~sync_in &  prev_q);

   // edge sources present their latch, level sources their (possibly inverted) line
   assign sensed = (edge_mode & latch_q) | (~edge_mode & (sync_in ^ low_mode));

   always_comb begin
      rise_d = rise_q;
      fall_d = fall_q;
      ack    = '0;
      if (wr_en) begin
         for (int b = 0; b < BANKS; b++) begin
            if (bank == BIDX_W'(b)) begin
               case (idx)
                  E_LATCH: ack[b*BANK_W +: BANK_W]    = wdata;
                  E_RISE:  rise_d[b*BANK_W +: BANK_W] = wdata;
                  E_FALL:  fall_d[b*BANK_W +: BANK_W] = wdata;
                  E_RSET:  rise_d[b*BANK_W +: BANK_W] = rise_q[b*BANK_W +: BANK_W] | wdata;
                  E_RCLR:  rise_d[b*BANK_W +: BANK_W] = rise_q[b*BANK_W +: BANK_W] & ~wdata;
                  E_FSET:  fall_d[b*BANK_W +: BANK_W] = fall_q[b*BANK_W +: BANK_W] | wdata;
                  E_FCLR:  fall_d[b*BANK_W +: BANK_W] = fall_q[b*BANK_W +: BANK_W] & ~wdata;
                  default: ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_q  <= '0;
         fall_q  <= '0;
         latch_q <= '0;
         prev_q  <= '0;
      end else begin
         rise_q  <= rise_d;
         fall_q  <= fall_d;
         prev_q  <= sync_in;
         // a fresh event outranks an acknowledge of the same bit
         latch_q <= (latch_q & ~ack) | evt;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int b = 0; b < BANKS; b++) begin
         if (bank == BIDX_W'(b)) begin
            case (idx)
               E_SENSE:                rd_word = sensed[b*BANK_W +: BANK_W];
               E_LATCH:                rd_word = latch_q[b*BANK_W +: BANK_W];
               E_RISE, E_RSET, E_RCLR: rd_word = rise_q[b*BANK_W +: BANK_W];
               default:                rd_word = fall_q[b*BANK_W +: BANK_W];
            endcase
         end
      end
   end

endmodule

// File: rtl/ihub_group.sv
module ihub_group
   import ihub_pkg::*;
#(
   parameter int BANK_W = 32,
   parameter int BANKS  = 2,
   parameter int BIDX_W = 1,
   localparam int N     = BANK_W * BANKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BIDX_W-1:0] bank,
   input  logic [2:0]        idx,
   input  logic [BANK_W-1:0] wdata,
   input  logic [N-1:0]      sensed,
   output logic [N-1:0]      en_q,
   output logic [BANK_W-1:0] rd_word,
   output logic              irq
);

   logic [N-1:0] soft_q, en_d, soft_d;
   logic [N-1:0] raw, status;

   assign raw    = sensed | soft_q;
   assign status = raw & en_q;
   assign irq    = |status;

   always_comb begin
      en_d   = en_q;
      soft_d = soft_q;
      if (wr_en) begin
         for (int b = 0; b < BANKS; b++) begin
            if (bank == BIDX_W'(b)) begin
               case (idx)
                  C_ENSET: en_d[b*BANK_W +: BANK_W]   = en_q[b*BANK_W +: BANK_W] | wdata;
                  C_ENCLR: en_d[b*BANK_W +: BANK_W]   = en_q[b*BANK_W +: BANK_W] & ~wdata;
                  C_SWSET: soft_d[b*BANK_W +: BANK_W] = soft_q[b*BANK_W +: BANK_W] | wdata;
                  C_SWCLR: soft_d[b*BANK_W +: BANK_W] = soft_q[b*BANK_W +: BANK_W] & ~wdata;
                  default: ;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         soft_q <= '0;
      end else begin
         en_q   <= en_d;
         soft_q <= soft_d;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int b = 0; b < BANKS; b++) begin
         if (bank == BIDX_W'(b)) begin
            case (idx)
               C_STAT:           rd_word = status[b*BANK_W +: BANK_W];
               C_RAW:            rd_word = raw[b*BANK_W +: BANK_W];
               C_ENSET, C_ENCLR: rd_word = en_q[b*BANK_W +: BANK_W];
               C_SWSET, C_SWCLR: rd_word = soft_q[b*BANK_W +: BANK_W];
               default:          rd_word = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/intr_fanin_hub.sv
module intr_fanin_hub
   import ihub_pkg::*;
#(
   parameter int BANK_W      = 32,
   parameter int BANKS       = 2,
   parameter int NUM_GROUPS  = 3,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 10,
   localparam int N          = BANK_W * BANKS,
   localparam int BIDX_W     = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [BANK_W-1:0]     bus_wdata,
   input  logic                  bus_rd,
   output logic [BANK_W-1:0]     bus_rdata,
   input  logic [N-1:0]          src_in,
   output logic [NUM_GROUPS-1:0] irq_out
);

   if (BANK_W != 32) begin : g_bad_width
      $error("intr_fanin_hub: bus words are 32 bits");
   end
   if (ADDR_W != 10) begin : g_bad_addr
      $error("intr_fanin_hub: map needs a 10-bit byte address");
   end
   if (NUM_GROUPS < 1 || NUM_GROUPS > 3) begin : g_bad_groups
      $error("intr_fanin_hub: one to three groups");
   end
   if (EDGE_REGS * BANKS > 64) begin : g_bad_banks
      $error("intr_fanin_hub: banks overflow a 256-byte page");
   end

   // ---------------- address decode ----------------
   logic [1:0]        page;
   logic [5:0]        word;
   logic              aligned;
   logic              c_ok, e_ok;
   logic [BIDX_W-1:0] c_bank, e_bank;
   logic [2:0]        c_idx, e_idx;

   assign page    = bus_addr[9:8];
   assign word    = bus_addr[7:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   always_comb begin
      c_bank = BIDX_W'(int'(word) / CTL_REGS);
      c_idx  = 3'(int'(word) % CTL_REGS);
      c_ok   = aligned && (int'(word) < CTL_REGS * BANKS);
      e_bank = BIDX_W'(int'(word) / EDGE_REGS);
      e_idx  = 3'(int'(word) % EDGE_REGS);
      e_ok   = aligned && (page == EDGE_PAGE) && (int'(word) < EDGE_REGS * BANKS);
   end

   // ---------------- sources ----------------
   logic [N-1:0] src_sync;

   ihub_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_in),
      .q     (src_sync)
   );

   logic [N-1:0]      sensed;
   logic [N-1:0]      trig_rise, trig_fall, trig_latch;
   logic [BANK_W-1:0] trig_rd;

   ihub_trigger #(.BANK_W(BANK_W), .BANKS(BANKS), .BIDX_W(BIDX_W)) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && e_ok),
      .bank    (e_bank),
      .idx     (e_idx),
      .wdata   (bus_wdata),
      .sync_in (src_sync),
      .sensed  (sensed),
      .rise_q  (trig_rise),
      .fall_q  (trig_fall),
      .latch_q (trig_latch),
      .rd_word (trig_rd)
   );

   // ---------------- output groups ----------------
   logic [N-1:0]      en_g   [NUM_GROUPS];
   logic [BANK_W-1:0] ctl_rd [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] grp_hit;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_hit[g] = c_ok && (page == grp_page(g));

      ihub_group #(.BANK_W(BANK_W), .BANKS(BANKS), .BIDX_W(BIDX_W)) u_grp (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bus_wr && grp_hit[g]),
         .bank    (c_bank),
         .idx     (c_idx),
         .wdata   (bus_wdata),
         .sensed  (sensed),
         .en_q    (en_g[g]),
         .rd_word (ctl_rd[g]),
         .irq     (irq_out[g])
      );
   end

   // ---------------- read path ----------------
   logic [BANK_W-1:0] rd_d;

   always_comb begin
      rd_d = '0;
      if (e_ok) rd_d = trig_rd;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp_hit[g]) rd_d = ctl_rd[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_d;
   end

endmodule

// File: rtl/ihub_checker.sv
module ihub_checker #(
   parameter int N          = 64,
   parameter int CTL_WORDS  = 12,
   parameter int EDGE_WORDS = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [9:0]   bus_addr,
   input logic         bus_wr,
   input logic [31:0]  bus_wdata,
   input logic         bus_rd,
   input logic [31:0]  bus_rdata,
   input logic         irq0,
   input logic [N-1:0] en0,
   input logic [N-1:0] latch,
   input logic [N-1:0] rise
);

   logic unmapped, any_ack;

   assign unmapped = (bus_addr[1:0] != 2'b00)
                   || ((bus_addr[9:8] != 2'd2) && (int'(bus_addr[7:2]) >= CTL_WORDS))
                   || ((bus_addr[9:8] == 2'd2) && (int'(bus_addr[7:2]) >= EDGE_WORDS));

   assign any_ack = bus_wr && (bus_addr[9:8] == 2'd2) && (bus_addr[4:2] == 3'd1);

   assert_enset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 10'h008) |=> ((en0[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

   assert_enclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 10'h00C) |=> ((en0[31:0] & $past(bus_wdata)) == 32'h0));

   assert_riseset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 10'h210) |=> ((rise[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

   assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !any_ack |=> ((latch & $past(latch)) == $past(latch)));

   assert_quiet_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en0 == '0) |-> !irq0);

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> (bus_rdata == 32'h0));

endmodule

bind intr_fanin_hub ihub_checker #(
   .N          (BANK_W * BANKS),
   .CTL_WORDS  (ihub_pkg::CTL_REGS * BANKS),
   .EDGE_WORDS (ihub_pkg::EDGE_REGS * BANKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .irq0      (irq_out[0]),
   .en0       (en_g[0]),
   .latch     (trig_latch),
   .rise      (trig_rise)
);

// File: tb/sim_intr_fanin_hub.sv
`timescale 1ns/1ps
module sim_intr_fanin_hub;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [63:0] src = '0;
   logic [2:0]  irq_out;

   always #2 clk = ~clk;

   intr_fanin_hub u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .src_in    (src),
      .irq_out   (irq_out)
   );

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   // bench model
   logic [63:0] m_en   [3];
   logic [63:0] m_soft [3];
   logic [63:0] m_rise = '0, m_fall = '0, m_lat = '0;

   function automatic logic [9:0] caddr(int g, int b, int r);
      int page = (g == 2) ? 3 : g;
      return 10'(page * 256 + b * 24 + r * 4);
   endfunction

   function automatic logic [9:0] eaddr(int b, int r);
      return 10'(512 + b * 32 + r * 4);
   endfunction

   function automatic logic [63:0] exp_sense();
      logic [63:0] r;
      for (int i = 0; i < 64; i++) begin
         case ({m_rise[i], m_fall[i]})
            2'b00:   r[i] = src[i];
            2'b11:   r[i] = ~src[i];
            default: r[i] = m_lat[i];
         endcase
      end
      return r;
   endfunction

   function automatic logic [2:0] exp_irq();
      logic [63:0] s = exp_sense();
      logic [2:0]  r;
      for (int g = 0; g < 3; g++) r[g] = |((s | m_soft[g]) & m_en[g]);
      return r;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rdchk(input logic [9:0] a, input logic [31:0] exp, input string req);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(bus_rdata, exp, req);
   endtask

   task automatic set_src(input logic [63:0] nv);
      for (int i = 0; i < 64; i++) begin
         if (m_rise[i] && !m_fall[i] && !src[i] && nv[i]) m_lat[i] = 1'b1;
         if (m_fall[i] && !m_rise[i] && src[i] && !nv[i]) m_lat[i] = 1'b1;
      end
      src = nv;
      repeat (4) @(negedge clk);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] s;
      logic [31:0] pat;
      for (int g = 0; g < 3; g++) begin m_en[g] = '0; m_soft[g] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state of every mapped word and the request outputs
      chk(32'(irq_out), 32'h0, "R10 irq after reset");
      for (int g = 0; g < 3; g++)
         for (int b = 0; b < 2; b++)
            for (int r = 0; r < 6; r++) rdchk(caddr(g, b, r), 32'h0, "R10 group reset");
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < 8; r++) rdchk(eaddr(b, r), 32'h0, "R10 trigger reset");

      // R10: unmapped words and misaligned addresses read zero
      for (int g = 0; g < 3; g++)
         for (int w = 12; w < 64; w++) rdchk(10'(caddr(g, 0, 0) + w * 4), 32'h0, "R10 group unmapped");
      for (int w = 16; w < 64; w++) rdchk(10'(512 + w * 4), 32'h0, "R10 trigger unmapped");

      // R1 R2: enable set/clear on every group and bank, both read aliases
      for (int g = 0; g < 3; g++)
         for (int b = 0; b < 2; b++) begin
            pat = 32'h9E37_79B9 * 32'(g * 2 + b + 1);
            wr(caddr(g, b, 2), pat);
            m_en[g][b*32 +: 32] = pat;
            rdchk(caddr(g, b, 2), pat, "R2 enable set");
            wr(caddr(g, b, 2), 32'h0000_FFFF);
            m_en[g][b*32 +: 32] |= 32'h0000_FFFF;
            wr(caddr(g, b, 3), 32'hF0F0_F0F0);
            m_en[g][b*32 +: 32] &= ~32'hF0F0_F0F0;
            rdchk(caddr(g, b, 3), m_en[g][b*32 +: 32], "R2 enable clear alias");
         end
      for (int g = 0; g < 3; g++)
         for (int b = 0; b < 2; b++) rdchk(caddr(g, b, 2), m_en[g][b*32 +: 32], "R1 bank isolation");
      chk(32'(irq_out), 32'h0, "R9 no request without raw");
      for (int g = 0; g < 3; g++)
         for (int b = 0; b < 2; b++) wr(caddr(g, b, 3), 32'hFFFF_FFFF);
      for (int g = 0; g < 3; g++) m_en[g] = '0;

      // R3 R8 R9: software pending per group and bank
      for (int g = 0; g < 3; g++)
         for (int b = 0; b < 2; b++) begin
            pat = 32'h1 << (g * 5 + b * 7);
            wr(caddr(g, b, 4), pat);
            rdchk(caddr(g, b, 5), pat, "R3 soft set");
            rdchk(caddr(g, b, 1), pat, "R8 raw has soft");
            rdchk(caddr(g, b, 0), 32'h0, "R8 status masked");
            chk(32'(irq_out), 32'h0, "R9 masked soft");
            wr(caddr(g, b, 2), pat);
            chk(32'(irq_out), 32'(3'b001 << g), "R9 one group");
            rdchk(caddr(g, b, 0), pat, "R8 status enabled");
            rdchk(caddr((g + 1) % 3, b, 1), 32'h0, "R9 other group raw");
            wr(caddr(g, b, 5), pat);
            rdchk(caddr(g, b, 4), 32'h0, "R3 soft clear");
            chk(32'(irq_out), 32'h0, "R9 cleared");
            wr(caddr(g, b, 3), pat);
         end

      // R4: configuration by aliases (low bank) and whole-word loads (high bank)
      wr(eaddr(0, 4), 32'h19); wr(eaddr(0, 5), 32'h10); wr(eaddr(0, 6), 32'hA);
      wr(eaddr(1, 2), 32'hFF); wr(eaddr(1, 2), 32'h9);  wr(eaddr(1, 3), 32'hA);
      wr(eaddr(1, 6), 32'h40); wr(eaddr(1, 7), 32'h40);
      m_rise = {32'h9, 32'h9}; m_fall = {32'hA, 32'hA};
      rdchk(eaddr(0, 2), 32'h9, "R4 rise word");
      rdchk(eaddr(0, 7), 32'hA, "R4 fall alias read");
      rdchk(eaddr(1, 5), 32'h9, "R4 rise load replaces");
      rdchk(eaddr(1, 3), 32'hA, "R4 fall load");
      wr(caddr(0, 0, 2), 32'hF); wr(caddr(0, 1, 2), 32'hF);
      m_en[0] = {32'hF, 32'hF};

      // R5 R6 R8 R9: every nibble transition on all four modes, both banks
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++) begin
            set_src({28'h0, 4'(a), 28'h0, 4'(a)});
            set_src({28'h0, 4'(b), 28'h0, 4'(b)});
            s = exp_sense();
            rdchk(eaddr(0, 0), s[31:0],  "R5 sensed low bank");
            rdchk(eaddr(1, 0), s[63:32], "R5 sensed high bank");
            rdchk(eaddr(0, 1), m_lat[31:0],  "R6 latch low bank");
            rdchk(eaddr(1, 1), m_lat[63:32], "R6 latch high bank");
            rdchk(caddr(0, 0, 1), s[31:0], "R8 raw");
            rdchk(caddr(0, 1, 0), s[63:32] & m_en[0][63:32], "R8 status");
            chk(32'(irq_out), 32'(exp_irq()), "R9 request");
            wr(eaddr(0, 1), 32'hF); wr(eaddr(1, 1), 32'hF);
            m_lat = '0;
            rdchk(eaddr(0, 1), 32'h0, "R7 acknowledge clears");
         end

      // R7: acknowledge of 0 bits leaves other latched events alone
      set_src(64'h2);
      set_src(64'h1);
      rdchk(eaddr(0, 1), 32'h3, "R7 two events");
      wr(eaddr(0, 1), 32'h1);
      m_lat[0] = 1'b0;
      rdchk(eaddr(0, 1), 32'h2, "R7 partial acknowledge");
      wr(eaddr(0, 1), 32'h2);
      m_lat[1] = 1'b0;
      set_src(64'h0);

      // R7: event arrives in the same cycle as its acknowledge
      src[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(eaddr(0, 1), 32'h1);
      repeat (2) @(negedge clk);
      rdchk(eaddr(0, 1), 32'h1, "R7 event beats acknowledge");
      wr(eaddr(0, 1), 32'h1);
      rdchk(eaddr(0, 1), 32'h0, "R7 second acknowledge");

      done = 1;
      summary();
      $finish;
   end

endmodule